// File: doc/BRIEF.md
# Cascaded CAM Address Output Controller

This block sits in each content-addressable memory device of a chained system. It decides which 16-bit value the device presents on the shared address output bus, and whether the device may drive that bus or must leave it floating. The bus is made of a page field in the upper bits and a location field in the lower bits. The block also produces the three active-low match flags (valid, found, multiple) seen by the rest of the chain.

Each access cycle is framed by the active-low cycle enable `e_n`. The controller captures the decoded cycle type and the addresses when `e_n` falls. It publishes the new bus value and the ownership once `e_n` has returned high, so the bus never changes while a cycle is in progress. Cycles that do not touch addressing leave the bus as it was. Ownership depends on the cycle: the device that was written or accessed, the lowest-priority device (for the table and for the system-full all-ones pattern), or every device on a broadcast.

After a compare, the bus and the flags follow the chain's resolved result until the next cycle begins. That result is then frozen, so a later highest-priority-match read restores it without a new compare. The output enable `oe_n` gates the drive at once, with no clock in the path.

Top module: `cam_addr_out_ctl`

## Requirements
- R1: While `rst_n` is low and after it, until the first cycle: `bus_val` is 0, `bus_oe` is 0, and `mv_n`, `mf_n`, `mm_n` are all 1.
- R2: `bus_oe` is 1 only when `oe_n` is 0 and this device owns the bus. `oe_n` high forces `bus_oe` to 0 in the same cycle, with no clock edge needed.
- R3: A cycle's inputs are sampled on the clock where `e_n` is first seen low. Its effect on `bus_val` and ownership appears after the clock where `e_n` is first seen high again. While `e_n` stays low, `bus_val` and `bus_oe` do not change.
- R4: The cycle codes are carried on `cyc_type`. A cycle with code 0 (register or other non-address cycle), or with the reserved code 7, leaves `bus_val` and ownership unchanged.
- R5: Code 1 (write at next free address) with `sys_full`=0: `bus_val` becomes `acc_addr` (page in bits 15:12, location in 11:0), and ownership equals `wr_here`.
- R6: Code 1 with `sys_full`=1: `bus_val` becomes all ones, and ownership equals `lowest_cfg`.
- R7: Code 2 (random CAM read or write): `bus_val` becomes `acc_addr`, and ownership equals `dev_sel`.
- R8: Code 3 (table read or write): `bus_val` becomes `acc_addr`, and ownership equals `lowest_cfg`.
- R9: Code 4 (broadcast write): `bus_val` becomes `acc_addr`, and the device owns the bus whatever the other inputs are.
- R10: Code 5 (compare): after it completes, and until the next fall of `e_n`, several outputs follow the chain inputs combinationally. `bus_val` follows `mtc_addr`. Ownership follows `mtc_win`. `mv_n`/`mf_n`/`mm_n` are the inverses of `cmp_mv`/`cmp_mf`/`cmp_mm`.
- R11: The flags never change while `e_n` stays low, including during a compare.
- R12: At the fall of `e_n` that follows a compare, the flags, match address and match ownership are frozen. Later changes of the chain inputs have no effect. Code 6 (highest-priority-match read) puts the frozen match address and ownership back on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| e_n | input | 1 | Active-low cycle enable |
| oe_n | input | 1 | Active-low output enable, gates the drive directly |
| cyc_type | input | 3 | Decoded cycle code (see R4 to R12) |
| acc_addr | input | 16 | Local access address, page in 15:12 |
| wr_here | input | 1 | The next-free write landed in this device |
| dev_sel | input | 1 | This device was the target of a random access |
| sys_full | input | 1 | The whole chain was full before the cycle |
| lowest_cfg | input | 1 | This device is configured as lowest priority |
| mtc_addr | input | 16 | Local highest match address from the compare engine |
| mtc_win | input | 1 | Chain says this device holds the winning match |
| cmp_mv | input | 1 | Compare result: match valid |
| cmp_mf | input | 1 | Compare result: match found |
| cmp_mm | input | 1 | Compare result: multiple match |
| bus_val | output | 16 | Value for the shared address bus |
| bus_oe | output | 1 | Drive enable for the shared address bus |
| mv_n | output | 1 | Match valid flag, active low |
| mf_n | output | 1 | Match found flag, active low |
| mm_n | output | 1 | Multiple match flag, active low |

## Verification
The assertions assume that `e_n` is a synchronous level: it is held for whole clock periods, so every low phase contains a sampled fall and ends in a sampled rise. They also assume that `oe_n` changes only between cycles, so the hold check is not confused by the asynchronous gate. The stimulus keeps `e_n` low for one to three full clocks and sets `oe_n` only while `e_n` is high. It changes the chain and access inputs freely during the low phase, which is exactly where the hold properties must not fire.

// File: rtl/cam_aoc_pkg.sv
`timescale 1ns/1ps
package cam_aoc_pkg;

   localparam int CYC_W = 3;

   typedef enum logic [CYC_W-1:0] {
      CYC_IDLE  = 3'd0,
      CYC_NFA   = 3'd1,
      CYC_CAM   = 3'd2,
      CYC_TBL   = 3'd3,
      CYC_BCAST = 3'd4,
      CYC_CMP   = 3'd5,
      CYC_HPM   = 3'd6,
      CYC_RSV   = 3'd7
   } cyc_e;

   // source of the visible bus value
   typedef enum logic {
      SRC_LATCH = 1'b0,
      SRC_MATCH = 1'b1
   } src_e;

   function automatic logic cyc_moves_addr(cyc_e c);
      return (c != CYC_IDLE) && (c != CYC_RSV);
   endfunction

endpackage

// File: rtl/cam_aoc_edge.sv
`timescale 1ns/1ps
// Detects the sampled falling and rising transitions of the cycle enable.
module cam_aoc_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic e_n,
   output logic e_fall,
   output logic e_rise
);
   logic e_q;

   always_ff @(posedge clk) begin
      if (!rst_n) e_q <= 1'b1;
      else        e_q <= e_n;
   end

   assign e_fall = e_q & ~e_n;
   assign e_rise = ~e_q & e_n;
endmodule

// File: rtl/cam_aoc_route.sv
`timescale 1ns/1ps
// Decodes one cycle into the bus value it would publish and who owns it.
module cam_aoc_route
   import cam_aoc_pkg::*;
#(
   parameter int BUS_W = 16
) (
   input  cyc_e             cyc,
   input  logic [BUS_W-1:0] acc_addr,
   input  logic             wr_here,
   input  logic             dev_sel,
   input  logic             sys_full,
   input  logic             lowest_cfg,
   output logic [BUS_W-1:0] nxt_val,
   output logic             nxt_own,
   output src_e             nxt_src,
   output logic             nxt_touch
);
   localparam logic [BUS_W-1:0] FULL_FILL = {BUS_W{1'b1}};

   always_comb begin
      nxt_val   = acc_addr;
      nxt_own   = 1'b0;
      nxt_src   = SRC_LATCH;
      nxt_touch = cyc_moves_addr(cyc);
      unique case (cyc)
         CYC_NFA: begin
            if (sys_full) begin
               nxt_val = FULL_FILL;
               nxt_own = lowest_cfg;
            end else begin
               nxt_own = wr_here;
            end
         end
         CYC_CAM:   nxt_own = dev_sel;
         CYC_TBL:   nxt_own = lowest_cfg;
         CYC_BCAST: nxt_own = 1'b1;
         CYC_CMP,
         CYC_HPM:   nxt_src = SRC_MATCH;
         default:   nxt_own = 1'b0;
      endcase
   end
endmodule

// File: rtl/cam_aoc_match.sv
`timescale 1ns/1ps
// Holds the compare result; follows the chain inputs while the window is open.
module cam_aoc_match #(
   parameter int BUS_W = 16,
   parameter int NFLAG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             e_fall,
   input  logic             open_win,
   input  logic [NFLAG-1:0] live_flag,
   input  logic [BUS_W-1:0] live_addr,
   input  logic             live_win,
   output logic [NFLAG-1:0] eff_flag,
   output logic [BUS_W-1:0] eff_addr,
   output logic             eff_win
);
   logic             follow_q;
   logic [BUS_W-1:0] addr_q;
   logic             win_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        follow_q <= 1'b0;
      else if (e_fall)   follow_q <= 1'b0;
      else if (open_win) follow_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         win_q  <= 1'b0;
      end else if (follow_q) begin
         addr_q <= live_addr;
         win_q  <= live_win;
      end
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      logic hold_q;
      always_ff @(posedge clk) begin
         if (!rst_n)        hold_q <= 1'b0;
         else if (follow_q) hold_q <= live_flag[i];
      end
      assign eff_flag[i] = follow_q ? live_flag[i] : hold_q;
   end

   assign eff_addr = follow_q ? live_addr : addr_q;
   assign eff_win  = follow_q ? live_win  : win_q;
endmodule

// File: rtl/cam_addr_out_ctl.sv
`timescale 1ns/1ps
module cam_addr_out_ctl
   import cam_aoc_pkg::*;
#(
   parameter int PAGE_W = 4,
   parameter int LOC_W  = 12,
   localparam int BUS_W = PAGE_W + LOC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             e_n,
   input  logic             oe_n,
   input  logic [CYC_W-1:0] cyc_type,
   input  logic [BUS_W-1:0] acc_addr,
   input  logic             wr_here,
   input  logic             dev_sel,
   input  logic             sys_full,
   input  logic             lowest_cfg,
   input  logic [BUS_W-1:0] mtc_addr,
   input  logic             mtc_win,
   input  logic             cmp_mv,
   input  logic             cmp_mf,
   input  logic             cmp_mm,
   output logic [BUS_W-1:0] bus_val,
   output logic             bus_oe,
   output logic             mv_n,
   output logic             mf_n,
   output logic             mm_n
);
   localparam int NFLAG = 3;

   if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
      $error("cam_addr_out_ctl: PAGE_W out of range");
   end
   if (LOC_W < 4 || LOC_W > 24) begin : g_bad_loc
      $error("cam_addr_out_ctl: LOC_W out of range");
   end

   logic e_fall, e_rise;

   cam_aoc_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .e_n    (e_n),
      .e_fall (e_fall),
      .e_rise (e_rise)
   );

   logic [BUS_W-1:0] nxt_val;
   logic             nxt_own;
   src_e             nxt_src;
   logic             nxt_touch;

   cam_aoc_route #(.BUS_W(BUS_W)) u_route (
      .cyc        (cyc_e'(cyc_type)),
      .acc_addr   (acc_addr),
      .wr_here    (wr_here),
      .dev_sel    (dev_sel),
      .sys_full   (sys_full),
      .lowest_cfg (lowest_cfg),
      .nxt_val    (nxt_val),
      .nxt_own    (nxt_own),
      .nxt_src    (nxt_src),
      .nxt_touch  (nxt_touch)
   );

   // captured at the fall of e_n
   cyc_e             pend_cyc;
   logic [BUS_W-1:0] pend_val;
   logic             pend_own;
   src_e             pend_src;
   logic             pend_touch;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_cyc   <= CYC_IDLE;
         pend_val   <= '0;
         pend_own   <= 1'b0;
         pend_src   <= SRC_LATCH;
         pend_touch <= 1'b0;
      end else if (e_fall) begin
         pend_cyc   <= cyc_e'(cyc_type);
         pend_val   <= nxt_val;
         pend_own   <= nxt_own;
         pend_src   <= nxt_src;
         pend_touch <= nxt_touch;
      end
   end

   // published at the rise of e_n
   logic [BUS_W-1:0] addr_q;
   logic             own_q;
   src_e             src_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         own_q  <= 1'b0;
         src_q  <= SRC_LATCH;
      end else if (e_rise && pend_touch) begin
         addr_q <= pend_val;
         own_q  <= pend_own;
         src_q  <= pend_src;
      end
   end

   logic             open_win;
   logic [NFLAG-1:0] eff_flag;
   logic [BUS_W-1:0] eff_addr;
   logic             eff_win;

   assign open_win = e_rise && (pend_cyc == CYC_CMP);

   cam_aoc_match #(.BUS_W(BUS_W), .NFLAG(NFLAG)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .e_fall    (e_fall),
      .open_win  (open_win),
      .live_flag ({cmp_mm, cmp_mf, cmp_mv}),
      .live_addr (mtc_addr),
      .live_win  (mtc_win),
      .eff_flag  (eff_flag),
      .eff_addr  (eff_addr),
      .eff_win   (eff_win)
   );

   logic owner;
   assign owner   = (src_q == SRC_MATCH) ? eff_win  : own_q;
   assign bus_val = (src_q == SRC_MATCH) ? eff_addr : addr_q;
   assign bus_oe  = owner & ~oe_n;
   assign mv_n    = ~eff_flag[0];
   assign mf_n    = ~eff_flag[1];
   assign mm_n    = ~eff_flag[2];
endmodule

// File: rtl/cam_aoc_chk.sv
`timescale 1ns/1ps
module cam_aoc_chk
   import cam_aoc_pkg::*;
#(
   parameter int BUS_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             e_n,
   input logic             oe_n,
   input logic [BUS_W-1:0] bus_val,
   input logic             bus_oe,
   input logic             mv_n,
   input logic             mf_n,
   input logic             mm_n,
   input logic             e_rise,
   input cyc_e             pend_cyc,
   input logic [BUS_W-1:0] addr_q,
   input logic             own_q
);
   p_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !bus_oe);

   p_bus_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!e_n && !$past(e_n) && $stable(oe_n)) |-> ($stable(bus_val) && $stable(bus_oe)));

   p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!e_n && !$past(e_n)) |-> $stable({mv_n, mf_n, mm_n}));

   p_idle_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (e_rise && (pend_cyc == CYC_IDLE || pend_cyc == CYC_RSV)) |=> ($stable(addr_q) && $stable(own_q)));

   p_bcast_own_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (e_rise && pend_cyc == CYC_BCAST) |=> own_q);
endmodule

bind cam_addr_out_ctl cam_aoc_chk #(.BUS_W(BUS_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .e_n      (e_n),
   .oe_n     (oe_n),
   .bus_val  (bus_val),
   .bus_oe   (bus_oe),
   .mv_n     (mv_n),
   .mf_n     (mf_n),
   .mm_n     (mm_n),
   .e_rise   (e_rise),
   .pend_cyc (pend_cyc),
   .addr_q   (addr_q),
   .own_q    (own_q)
);

// File: tb/cam_addr_out_ctl_bench.sv
`timescale 1ns/1ps
module cam_addr_out_ctl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        e_n = 1'b1;
   logic        oe_n = 1'b0;
   logic [2:0]  cyc = 3'd0;
   logic [15:0] acc = 16'h0;
   logic        wr_here = 1'b0, dev_sel = 1'b0, sys_full = 1'b0, lowest = 1'b0;
   logic [15:0] l_addr = 16'h0;
   logic        l_win = 1'b0;
   logic [2:0]  l_flag = 3'b0;   // [0]=valid [1]=found [2]=multiple
   logic [15:0] bus_val;
   logic        bus_oe, mv_n, mf_n, mm_n;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   cam_addr_out_ctl u_cam_addr_out_ctl (
      .clk(clk), .rst_n(rst_n), .e_n(e_n), .oe_n(oe_n), .cyc_type(cyc),
      .acc_addr(acc), .wr_here(wr_here), .dev_sel(dev_sel), .sys_full(sys_full),
      .lowest_cfg(lowest), .mtc_addr(l_addr), .mtc_win(l_win),
      .cmp_mv(l_flag[0]), .cmp_mf(l_flag[1]), .cmp_mm(l_flag[2]),
      .bus_val(bus_val), .bus_oe(bus_oe), .mv_n(mv_n), .mf_n(mf_n), .mm_n(mm_n));

   // reference model state
   logic [15:0] m_a = 16'h0;
   logic        m_own = 1'b0, m_src = 1'b0, m_follow = 1'b0;
   logic [15:0] s_addr = 16'h0;
   logic        s_win = 1'b0;
   logic [2:0]  s_flag = 3'b0;
   logic [15:0] p_val = 16'h0;
   logic        p_own = 1'b0, p_src = 1'b0, p_touch = 1'b0;
   logic [2:0]  p_cyc = 3'd0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_val();
      return m_src ? (m_follow ? l_addr : s_addr) : m_a;
   endfunction
   function automatic logic exp_drv();
      return (m_src ? (m_follow ? l_win : s_win) : m_own) & ~oe_n;
   endfunction
   function automatic logic [2:0] exp_flg_n();
      return ~(m_follow ? l_flag : s_flag);
   endfunction
   function automatic string tag_of(input logic [2:0] c, input logic full);
      case (c)
         3'd1:    return full ? "R6" : "R5";
         3'd2:    return "R7";
         3'd3:    return "R8";
         3'd4:    return "R9";
         3'd5:    return "R10";
         3'd6:    return "R12";
         default: return "R4";
      endcase
   endfunction

   task automatic check_all(input string tag);
      check(tag, 32'(bus_val), 32'(exp_val()));
      check(oe_n ? "R2" : tag, 32'(bus_oe), 32'(exp_drv()));
      check(m_follow ? "R10" : "R12", 32'({mm_n, mf_n, mv_n}), 32'(exp_flg_n()));
   endtask

   task automatic model_fall();
      p_cyc = cyc; p_val = acc; p_own = 1'b0; p_src = 1'b0;
      p_touch = (cyc != 3'd0) && (cyc != 3'd7);
      case (cyc)
         3'd1: if (sys_full) begin p_val = 16'hFFFF; p_own = lowest; end
               else p_own = wr_here;
         3'd2: p_own = dev_sel;
         3'd3: p_own = lowest;
         3'd4: p_own = 1'b1;
         3'd5, 3'd6: p_src = 1'b1;
         default: ;
      endcase
      if (m_follow) begin s_addr = l_addr; s_win = l_win; s_flag = l_flag; end
      m_follow = 1'b0;
   endtask

   task automatic model_rise();
      if (p_touch) begin m_a = p_val; m_own = p_own; m_src = p_src; end
      if (p_cyc == 3'd5) m_follow = 1'b1;
   endtask

   task automatic run_cycle(input logic [2:0] c, input logic wh, input logic ds,
                            input logic fu, input logic lo, input logic [15:0] a,
                            input int low, input logic o);
      logic [15:0] sv;
      logic        sd;
      logic [2:0]  sf;
      @(negedge clk);
      cyc = c; wr_here = wh; dev_sel = ds; sys_full = fu; lowest = lo; acc = a; oe_n = o;
      #1;
      sv = bus_val; sd = bus_oe; sf = {mm_n, mf_n, mv_n};
      e_n = 1'b0;
      @(negedge clk);
      model_fall();
      // perturb everything while e_n stays low: nothing may move (R3, R11)
      acc = 16'($urandom); wr_here = 1'($urandom); dev_sel = 1'($urandom);
      sys_full = 1'($urandom); lowest = 1'($urandom); cyc = 3'($urandom);
      l_addr = 16'($urandom); l_win = 1'($urandom); l_flag = 3'($urandom);
      #1;
      check("R3", 32'(bus_val), 32'(sv));
      check("R3", 32'(bus_oe), 32'(sd));
      check("R11", 32'({mm_n, mf_n, mv_n}), 32'(sf));
      for (int i = 1; i < low; i++) @(negedge clk);
      e_n = 1'b1;
      @(negedge clk);
      model_rise();
      #1;
      check_all(tag_of(c, fu));
   endtask

   task automatic poke_live(input logic [15:0] a, input logic w, input logic [2:0] f);
      @(negedge clk);
      l_addr = a; l_win = w; l_flag = f;
      #1;
      check_all(m_follow ? "R10" : "R12");
   endtask

   initial begin
      #800000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (4) @(negedge clk);
      #1;
      check("R1", 32'(bus_val), 32'h0);
      check("R1", 32'(bus_oe), 32'h0);
      check("R1", 32'({mm_n, mf_n, mv_n}), 32'h7);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check("R1", 32'(bus_val), 32'h0);
      check("R1", 32'({mm_n, mf_n, mv_n}), 32'h7);

      // directed corner cases
      run_cycle(3'd2, 0, 1, 0, 0, 16'h1234, 1, 1'b0);        // R7 owner
      @(negedge clk); oe_n = 1'b1; #1;
      check("R2", 32'(bus_oe), 32'h0);
      oe_n = 1'b0; #1;
      check("R2", 32'(bus_oe), 32'h1);
      run_cycle(3'd0, 1, 1, 1, 1, 16'hBEEF, 2, 1'b0);        // R4
      run_cycle(3'd7, 1, 1, 1, 1, 16'hCAFE, 1, 1'b0);        // R4 reserved
      run_cycle(3'd1, 0, 0, 1, 1, 16'h0F0F, 1, 1'b0);        // R6 lowest drives ones
      run_cycle(3'd1, 1, 1, 1, 0, 16'h0F0F, 1, 1'b0);        // R6 others float
      run_cycle(3'd1, 0, 1, 0, 1, 16'hA5A5, 3, 1'b0);        // R5 not the writer
      run_cycle(3'd1, 1, 0, 0, 0, 16'h5A5A, 1, 1'b0);        // R5 writer
      run_cycle(3'd3, 0, 0, 0, 1, 16'h0042, 1, 1'b0);        // R8
      run_cycle(3'd4, 0, 0, 0, 0, 16'h7777, 1, 1'b0);        // R9
      run_cycle(3'd5, 0, 0, 0, 0, 16'h0000, 2, 1'b0);        // compare, R11 during low
      poke_live(16'h2ABC, 1'b1, 3'b011);                     // R10 follows
      poke_live(16'h3DEF, 1'b0, 3'b101);                     // R10 follows
      run_cycle(3'd0, 0, 0, 0, 0, 16'h0000, 1, 1'b0);        // freeze at fall
      poke_live(16'h1111, 1'b1, 3'b111);                     // R12 frozen
      run_cycle(3'd3, 0, 0, 0, 1, 16'h0099, 1, 1'b0);        // bus moved to table
      run_cycle(3'd6, 0, 0, 0, 0, 16'h0000, 1, 1'b0);        // R12 restore match

      // constrained random
      for (int k = 0; k < 400; k++) begin
         if ($urandom % 3 == 0)
            poke_live(16'($urandom), 1'($urandom), 3'($urandom));
         run_cycle(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
                   1'($urandom), 16'($urandom), 1 + int'($urandom % 3),
                   1'($urandom % 4 == 0));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule